// File: doc/BRIEF.md
# Edge-Detect GPIO Interrupt Controller

This block monitors a vector of already-synchronized general-purpose inputs and turns selected signal transitions into pending events. Each pin can be armed for a rising transition, a falling transition, or both. A detected transition is recorded in two status views, A and B. Each view has its own mask and its own interrupt request line, so two consumers can each service their own subset of pins.

Software reaches the block through a byte-wide register port. This port has an 8-bit address, a write strobe with write data, and a read strobe. Read data is combinational from the address. A pending event is acknowledged by writing a one to its status bit. A control register selects three options:
- clear-on-read acknowledge.
- latching gated by the mask.
- routing of events to view A only.

Top module: `gpio_eirq`

## Requirements
- R1: After reset every mask bit is 1, so bytes 0x1C/0x1D and 0x22/0x23 read 0xFF and bytes 0x1E and 0x24 read 0x03. All status bits, edge-select bits and control bits are 0, and both request lines are low.
- R2: Edge-select byte 0x28+c covers pins 4c..4c+3. For the pin at position k in that byte, bit 2k arms falling detection and bit 2k+1 arms rising detection, and both may be set at once. An armed transition seen at a clock edge sets that pin's status bit, readable right after that edge.
- R3: A transition of a kind that is not armed for that pin sets no status bit.
- R4: View A status is at 0x19..0x1B and view B status is at 0x1F..0x21. Byte j bit i holds pin 8j+i. Bits for pins above 17 read 0 and ignore writes, and the same layout applies to the masks at 0x1C..0x1E (A) and 0x22..0x24 (B).
- R5: Writing a status byte clears each bit written as 1 and leaves each bit written as 0 unchanged. A new transition on the same clock edge as its clear leaves the bit set.
- R6: A request line is high exactly when some status bit of its view is 1 and the matching mask bit of that view is 0. Status bits latch whatever the mask, unless R7 applies.
- R7: With control bit 1 (pending-disable) set, a transition does not set the status bit of a pin that is masked in that view.
- R8: With control bit 0 (exclusive) set, transitions set status bits in view A only and view B is left unchanged.
- R9: With control bit 2 (clear-on-read) set, a read strobe on a status byte clears the bits it returned, but a transition on that same edge stays set. With bit 2 clear, reads change nothing.
- R10: The control register at 0x2D reads back its bits 2:0 with upper bits 0, and any unmapped address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | 18 | Synchronized pin levels |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe; only affects state under clear-on-read |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_a_o | output | 1 | Request line of view A |
| irq_b_o | output | 1 | Request line of view B |

## Verification
A status bit latched into the wrong view or the wrong byte lane shows up on the next read of that byte. If the pin is unmasked, a wrong request level also appears on the request line one edge after the transition. A lost previous-level sample shows up as a spurious or missing event at the next armed transition. A broken clear priority leaves a bit missing after an acknowledge that coincides with a transition. Because the read port is combinational, every stored byte can be compared on every cycle, so a corrupted register is seen on the first read after it goes wrong.

// File: rtl/gpio_eirq_pkg.sv
`timescale 1ns/1ps
package gpio_eirq_pkg;

   // control register layout, bit 2 down to bit 0
   typedef struct packed {
      logic cor;       // clear status on read
      logic pend_dis;  // do not latch masked pins
      logic excl;      // latch into view A only
   } eirq_ctl_t;

   function automatic int bytes_for(input int nbits);
      return (nbits + 7) / 8;
   endfunction

endpackage

// File: rtl/gpio_eirq_edge.sv
`timescale 1ns/1ps
module gpio_eirq_edge #(
   parameter int NPIN = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPIN-1:0]   pins_i,
   input  logic [2*NPIN-1:0] cfg_i,
   output logic [NPIN-1:0]   evt_o
);

   logic [NPIN-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins_i;
   end

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      logic rise, fall;
      assign rise     = pins_i[p] & ~prev_q[p];
      assign fall     = ~pins_i[p] & prev_q[p];
      assign evt_o[p] = (cfg_i[2*p+1] & rise) | (cfg_i[2*p] & fall);
   end

endmodule

// File: rtl/gpio_eirq_view.sv
`timescale 1ns/1ps
module gpio_eirq_view
   import gpio_eirq_pkg::*;
#(
   parameter int NPIN      = 18,
   parameter int STAT_BASE = 'h19,
   parameter int MASK_BASE = 'h1C
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      addr_i,
   input  logic            wr_i,
   input  logic [7:0]      wdata_i,
   input  logic            rd_i,
   input  logic            cor_i,
   input  logic            pend_dis_i,
   input  logic            gate_i,
   input  logic [NPIN-1:0] evt_i,
   output logic [NPIN-1:0] stat_o,
   output logic [NPIN-1:0] mask_o,
   output logic [7:0]      rdata_o,
   output logic            hit_o,
   output logic            irq_o
);

   localparam int NB = bytes_for(NPIN);

   logic [NPIN-1:0] stat_q, mask_q, clr, set;

   always_comb begin
      for (int i = 0; i < NPIN; i++) begin
         logic sel;
         sel    = (addr_i == 8'(STAT_BASE + i / 8));
         clr[i] = sel && ((wr_i && wdata_i[i % 8]) || (cor_i && rd_i));
         set[i] = gate_i && evt_i[i] && !(pend_dis_i && mask_q[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '1;
      end else begin
         stat_q <= (stat_q & ~clr) | set;
         if (wr_i) begin
            for (int i = 0; i < NPIN; i++) begin
               if (addr_i == 8'(MASK_BASE + i / 8)) mask_q[i] <= wdata_i[i % 8];
            end
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      hit_o   = 1'b0;
      for (int j = 0; j < NB; j++) begin
         if (addr_i == 8'(STAT_BASE + j)) begin
            hit_o = 1'b1;
            for (int b = 0; b < 8; b++)
               if (8 * j + b < NPIN) rdata_o[b] = stat_q[8*j+b];
         end
         if (addr_i == 8'(MASK_BASE + j)) begin
            hit_o = 1'b1;
            for (int b = 0; b < 8; b++)
               if (8 * j + b < NPIN) rdata_o[b] = mask_q[8*j+b];
         end
      end
   end

   assign irq_o  = |(stat_q & ~mask_q);
   assign stat_o = stat_q;
   assign mask_o = mask_q;

endmodule

// File: rtl/gpio_eirq.sv
`timescale 1ns/1ps
module gpio_eirq
   import gpio_eirq_pkg::*;
#(
   parameter int NPIN      = 18,
   parameter int STAT_A    = 'h19,
   parameter int MASK_A    = 'h1C,
   parameter int STAT_B    = 'h1F,
   parameter int MASK_B    = 'h22,
   parameter int EDGE_BASE = 'h28,
   parameter int CTRL_ADDR = 'h2D
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pins_i,
   input  logic [7:0]      addr_i,
   input  logic            wr_i,
   input  logic [7:0]      wdata_i,
   input  logic            rd_i,
   output logic [7:0]      rdata_o,
   output logic            irq_a_o,
   output logic            irq_b_o
);

   localparam int NB  = bytes_for(NPIN);
   localparam int NCB = bytes_for(2 * NPIN);

   // elaboration-time parameter checks
   if (NPIN < 1 || NPIN > 64) begin : g_bad_npin
      $error("gpio_eirq: NPIN out of range");
   end
   if (STAT_A + NB > MASK_A || STAT_B + NB > MASK_B) begin : g_bad_overlap
      $error("gpio_eirq: status and mask ranges overlap");
   end
   if (EDGE_BASE + NCB > 256 || CTRL_ADDR > 255 || MASK_B + NB > 256) begin : g_bad_addr
      $error("gpio_eirq: register range exceeds address space");
   end

   eirq_ctl_t         ctrl_q;
   logic [2*NPIN-1:0] cfg_q;
   logic [NPIN-1:0]   evt;
   logic [NPIN-1:0]   stat_v [2];
   logic [NPIN-1:0]   mask_v [2];
   logic [7:0]        rd_v   [2];
   logic              hit_v  [2];
   logic              irq_v  [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         ctrl_q <= '0;
      end else if (wr_i) begin
         for (int k = 0; k < 2 * NPIN; k++) begin
            if (addr_i == 8'(EDGE_BASE + k / 8)) cfg_q[k] <= wdata_i[k % 8];
         end
         if (addr_i == 8'(CTRL_ADDR)) ctrl_q <= wdata_i[2:0];
      end
   end

   gpio_eirq_edge #(.NPIN(NPIN)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pins_i (pins_i),
      .cfg_i  (cfg_q),
      .evt_o  (evt)
   );

   for (genvar v = 0; v < 2; v++) begin : g_view
      localparam int SB = (v == 0) ? STAT_A : STAT_B;
      localparam int MB = (v == 0) ? MASK_A : MASK_B;
      logic gate;
      if (v == 0) begin : g_prim
         assign gate = 1'b1;
      end else begin : g_sec
         assign gate = !ctrl_q.excl;
      end
      gpio_eirq_view #(.NPIN(NPIN), .STAT_BASE(SB), .MASK_BASE(MB)) u_view (
         .clk        (clk),
         .rst_n      (rst_n),
         .addr_i     (addr_i),
         .wr_i       (wr_i),
         .wdata_i    (wdata_i),
         .rd_i       (rd_i),
         .cor_i      (ctrl_q.cor),
         .pend_dis_i (ctrl_q.pend_dis),
         .gate_i     (gate),
         .evt_i      (evt),
         .stat_o     (stat_v[v]),
         .mask_o     (mask_v[v]),
         .rdata_o    (rd_v[v]),
         .hit_o      (hit_v[v]),
         .irq_o      (irq_v[v])
      );
   end

   always_comb begin
      rdata_o = '0;
      if (hit_v[0])      rdata_o = rd_v[0];
      else if (hit_v[1]) rdata_o = rd_v[1];
      for (int c = 0; c < NCB; c++) begin
         if (addr_i == 8'(EDGE_BASE + c)) begin
            for (int b = 0; b < 8; b++)
               if (8 * c + b < 2 * NPIN) rdata_o[b] = cfg_q[8*c+b];
         end
      end
      if (addr_i == 8'(CTRL_ADDR)) rdata_o = {5'b0, ctrl_q};
   end

   assign irq_a_o = irq_v[0];
   assign irq_b_o = irq_v[1];

   // named views for the bound checker
   logic [NPIN-1:0] stat_a, stat_b, mask_a;
   logic [2:0]      ctrl_bits;
   assign stat_a    = stat_v[0];
   assign stat_b    = stat_v[1];
   assign mask_a    = mask_v[0];
   assign ctrl_bits = ctrl_q;

endmodule

// File: rtl/gpio_eirq_chk.sv
`timescale 1ns/1ps
module gpio_eirq_chk #(
   parameter int NPIN   = 18,
   parameter int STAT_A = 'h19
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_i,
   input logic [7:0]      addr_i,
   input logic [7:0]      wdata_i,
   input logic [NPIN-1:0] evt,
   input logic [2:0]      ctrl_bits,
   input logic [NPIN-1:0] stat_a,
   input logic [NPIN-1:0] stat_b,
   input logic [NPIN-1:0] mask_a
);

   // R2: every detected transition is present in view A after the edge
   a_r2_event_in_view_a: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(evt) & ~($past(ctrl_bits[1]) ? $past(mask_a) : {NPIN{1'b0}})) & ~stat_a) == {NPIN{1'b0}})
      else $error("a_r2_event_in_view_a");

   // R5: acknowledge of pin 0 without a new event leaves it clear
   a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_i && addr_i == 8'(STAT_A) && wdata_i[0]) && !$past(evt[0])) |-> !stat_a[0])
      else $error("a_r5_ack_clears");

   // R7: masked pins never become newly pending under pending-disable
   a_r7_masked_not_latched: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_bits[1]) |-> (stat_a & ~$past(stat_a) & $past(mask_a)) == {NPIN{1'b0}})
      else $error("a_r7_masked_not_latched");

   // R8: no new bits in view B under exclusive routing
   a_r8_view_b_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_bits[0]) |-> (stat_b & ~$past(stat_b)) == {NPIN{1'b0}})
      else $error("a_r8_view_b_frozen");

   // R9: without clear-on-read and without writes, status only grows
   a_r9_no_silent_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctrl_bits[2]) && !$past(wr_i)) |-> ($past(stat_a) & ~stat_a) == {NPIN{1'b0}})
      else $error("a_r9_no_silent_clear");

endmodule

bind gpio_eirq gpio_eirq_chk #(.NPIN(NPIN), .STAT_A(STAT_A)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_i      (wr_i),
   .addr_i    (addr_i),
   .wdata_i   (wdata_i),
   .evt       (evt),
   .ctrl_bits (ctrl_bits),
   .stat_a    (stat_a),
   .stat_b    (stat_b),
   .mask_a    (mask_a)
);

// File: tb/test_gpio_eirq.sv
`timescale 1ns/1ps
module test_gpio_eirq;

   localparam int N = 18;
   localparam logic [17:0] P17 = 18'h20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pins = '0;
   logic [7:0]   addr = '0, wdata = '0;
   logic         wr = 1'b0, rd = 1'b0;
   logic [7:0]   rdata;
   logic         irq_a, irq_b;

   always #2.5 clk = ~clk;

   gpio_eirq i_gpio_eirq (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .addr_i(addr), .wr_i(wr),
      .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .irq_a_o(irq_a), .irq_b_o(irq_b)
   );

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // reference state
   logic [35:0]  m_cfg;
   logic [N-1:0] m_sa, m_sb, m_ma, m_mb, m_prev, cur_p;
   logic [2:0]   m_ctl;
   logic [7:0]   last_rd;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] m_read(input logic [7:0] a);
      logic [23:0] sa, sb, ma, mb;
      logic [39:0] cf;
      sa = {6'b0, m_sa}; sb = {6'b0, m_sb}; ma = {6'b0, m_ma}; mb = {6'b0, m_mb};
      cf = {4'b0, m_cfg};
      if (a >= 8'h19 && a <= 8'h1B) return 8'(sa >> (8 * (a - 8'h19)));
      if (a >= 8'h1C && a <= 8'h1E) return 8'(ma >> (8 * (a - 8'h1C)));
      if (a >= 8'h1F && a <= 8'h21) return 8'(sb >> (8 * (a - 8'h1F)));
      if (a >= 8'h22 && a <= 8'h24) return 8'(mb >> (8 * (a - 8'h22)));
      if (a >= 8'h28 && a <= 8'h2C) return 8'(cf >> (8 * (a - 8'h28)));
      if (a == 8'h2D) return {5'b0, m_ctl};
      return 8'h00;
   endfunction

   task automatic m_update(input logic [N-1:0] p, input logic w, input logic [7:0] a,
                           input logic [7:0] d, input logic r);
      logic [N-1:0] ev, seta, setb;
      logic [23:0]  clra, clrb, nma, nmb;
      logic [39:0]  ncf;
      for (int i = 0; i < N; i++)
         ev[i] = (m_cfg[2*i+1] & p[i] & ~m_prev[i]) | (m_cfg[2*i] & ~p[i] & m_prev[i]);
      clra = '0; clrb = '0;
      nma = {6'b0, m_ma}; nmb = {6'b0, m_mb}; ncf = {4'b0, m_cfg};
      for (int j = 0; j < 3; j++) begin
         if (a == 8'(8'h19 + j)) begin
            if (w) clra |= 24'(d) << (8 * j);
            if (r && m_ctl[2]) clra |= 24'hFF << (8 * j);
         end
         if (a == 8'(8'h1F + j)) begin
            if (w) clrb |= 24'(d) << (8 * j);
            if (r && m_ctl[2]) clrb |= 24'hFF << (8 * j);
         end
         if (w && a == 8'(8'h1C + j)) nma[8*j +: 8] = d;
         if (w && a == 8'(8'h22 + j)) nmb[8*j +: 8] = d;
      end
      for (int c = 0; c < 5; c++) if (w && a == 8'(8'h28 + c)) ncf[8*c +: 8] = d;
      seta = ev & (m_ctl[1] ? ~m_ma : {N{1'b1}});
      setb = m_ctl[0] ? '0 : ev & (m_ctl[1] ? ~m_mb : {N{1'b1}});
      m_sa = (m_sa & ~clra[N-1:0]) | seta;
      m_sb = (m_sb & ~clrb[N-1:0]) | setb;
      m_ma = nma[N-1:0];
      m_mb = nmb[N-1:0];
      m_cfg = ncf[35:0];
      if (w && a == 8'h2D) m_ctl = d[2:0];
      m_prev = p;
   endtask

   // one bus cycle, entered and left at a falling clock edge
   task automatic step(input logic [N-1:0] p, input logic w, input logic [7:0] a,
                       input logic [7:0] d, input logic r);
      pins = p; wr = w; addr = a; wdata = d; rd = r;
      #1;
      last_rd = rdata;
      chk("R4 read data", {24'b0, rdata}, {24'b0, m_read(a)});
      @(posedge clk);
      m_update(p, w, a, d, r);
      @(negedge clk);
      chk("R6 irq_a", {31'b0, irq_a}, {31'b0, |(m_sa & ~m_ma)});
      chk("R6 irq_b", {31'b0, irq_b}, {31'b0, |(m_sb & ~m_mb)});
   endtask

   task automatic wreg(input logic [7:0] a, input logic [7:0] d);
      step(cur_p, 1'b1, a, d, 1'b0);
   endtask

   task automatic rreg(input logic [7:0] a, input string tag, input logic [7:0] exp);
      step(cur_p, 1'b0, a, 8'h00, 1'b0);
      chk(tag, {24'b0, last_rd}, {24'b0, exp});
   endtask

   task automatic setp(input logic [N-1:0] p);
      cur_p = p;
      step(cur_p, 1'b0, 8'h00, 8'h00, 1'b0);
   endtask

   initial begin
      #1ms;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20417));
      m_cfg = '0; m_sa = '0; m_sb = '0; m_ma = '1; m_mb = '1; m_prev = '0; m_ctl = '0;
      cur_p = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rreg(8'h1C, "R1 mask A byte0", 8'hFF);
      rreg(8'h1E, "R1 mask A byte2", 8'h03);
      rreg(8'h24, "R1 mask B byte2", 8'h03);
      rreg(8'h19, "R1 status A", 8'h00);
      rreg(8'h2D, "R1 control", 8'h00);
      chk("R1 irq low", {30'b0, irq_a, irq_b}, 32'd0);

      // R2 arm pin0 rising, pin4 both edges
      wreg(8'h28, 8'h02);
      wreg(8'h29, 8'h03);
      setp(cur_p | 18'h1);
      rreg(8'h19, "R2 pin0 rise view A", 8'h01);
      chk("R6 masked pending gives no irq", {31'b0, irq_a}, 32'd0);
      rreg(8'h1F, "R2 pin0 rise view B", 8'h01);
      wreg(8'h1C, 8'hFE);
      chk("R6 unmasked irq_a", {31'b0, irq_a}, 32'd1);
      wreg(8'h19, 8'h01);
      rreg(8'h19, "R5 w1c clears", 8'h00);
      setp(cur_p & ~18'h1);
      rreg(8'h19, "R3 unarmed fall ignored", 8'h00);
      setp(cur_p | 18'h10);
      rreg(8'h19, "R2 pin4 rise", 8'h10);
      wreg(8'h19, 8'h00);
      rreg(8'h19, "R5 zero write keeps", 8'h10);
      cur_p = cur_p & ~18'h10;
      step(cur_p, 1'b1, 8'h19, 8'h10, 1'b0);
      rreg(8'h19, "R5 edge beats clear", 8'h10);

      // R4 top byte lane, pin17 rising at 0x2C bit3
      wreg(8'h2C, 8'h08);
      setp(cur_p | P17);
      rreg(8'h1B, "R4 pin17 in A byte2", 8'h02);
      rreg(8'h21, "R4 pin17 in B byte2", 8'h02);
      wreg(8'h1E, 8'hFF);
      rreg(8'h1E, "R4 upper mask bits zero", 8'h03);

      // R8 exclusive
      wreg(8'h2D, 8'h01);
      wreg(8'h1B, 8'h02);
      wreg(8'h21, 8'h02);
      setp(cur_p & ~P17);
      setp(cur_p | P17);
      rreg(8'h1B, "R8 view A latches", 8'h02);
      rreg(8'h21, "R8 view B untouched", 8'h00);

      // R7 pending-disable
      wreg(8'h2D, 8'h02);
      wreg(8'h1B, 8'h02);
      wreg(8'h24, 8'h00);
      setp(cur_p & ~P17);
      setp(cur_p | P17);
      rreg(8'h1B, "R7 masked A not latched", 8'h00);
      rreg(8'h21, "R7 unmasked B latched", 8'h02);
      chk("R6 irq_b from pin17", {31'b0, irq_b}, 32'd1);

      // R9 clear-on-read
      wreg(8'h2D, 8'h00);
      step(cur_p, 1'b0, 8'h21, 8'h00, 1'b1);
      rreg(8'h21, "R9 plain read keeps", 8'h02);
      wreg(8'h2D, 8'h04);
      step(cur_p, 1'b0, 8'h21, 8'h00, 1'b1);
      chk("R9 read returns pending", {24'b0, last_rd}, 32'h02);
      rreg(8'h21, "R9 cleared by read", 8'h00);
      setp(cur_p & ~P17);
      cur_p = cur_p | P17;
      step(cur_p, 1'b0, 8'h21, 8'h00, 1'b1);
      rreg(8'h21, "R9 same-edge event kept", 8'h02);

      // R10 control readback and unmapped addresses
      wreg(8'h2D, 8'hFF);
      rreg(8'h2D, "R10 control readback", 8'h07);
      rreg(8'h00, "R10 unmapped 0x00", 8'h00);
      rreg(8'h25, "R10 unmapped 0x25", 8'h00);
      wreg(8'h2D, 8'h00);

      // constrained random traffic, all checks against the reference
      for (int n = 0; n < 4000; n++) begin
         logic       w, r;
         logic [7:0] a, d;
         if ($urandom % 10 < 4) cur_p = cur_p ^ (18'h1 << ($urandom % N));
         w = ($urandom % 10) < 3;
         r = $urandom % 2;
         a = 8'(8'h18 + $urandom % 22);
         d = 8'($urandom);
         step(cur_p, w, a, d, r);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule